// File: doc/BRIEF.md
# DRAM Refresh Interval Controller

This block schedules refresh cycles for dynamic memory on a small processor bus. A free-running down-counter counts CPU clock states. Its period comes from a 2-bit interval select, and each time it expires it raises a refresh request. The request is held in a one-bit pending flag. A pending refresh starts at the next machine-cycle boundary on which the processor owns the bus, is awake and is not stretching a cycle with wait states.

When a refresh runs, the block raises a refresh strobe for a fixed number of clocks and drives a 7-bit row address. The row address advances once each refresh completes. The block also drives a busy indication, which tells the core that the coming bus slot belongs to refresh. Handing the bus to an external master drops any owed refresh. A request that comes up during sleep is kept and replayed once sleep ends. Neither case, nor a replay, moves the timer phase.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: The interval select gives the number of clock cycles between refresh requests: 00 gives 10 cycles, 01 gives 20, 10 gives 40 and 11 gives 80. When machine cycles end on every clock with no stalls, successive strobe rises are spaced by exactly that count.
- R2: Reset sets the interval select to 00, holds the strobe and busy low and clears the row address to 0. If machine cycles end every clock after reset is released, the first strobe appears in the 11th cycle.
- R3: Each refresh strobe stays high for exactly 3 consecutive clock cycles.
- R4: A strobe rises only in the cycle after a cycle that had a refresh pending, a machine-cycle-end pulse, and none of bus release, sleep or wait. Busy is high in that starting cycle and for the whole strobe.
- R5: A request that arrives while the bus is released is discarded, and so is a request already pending when release begins. The timer keeps counting during release, so the next strobe after the bus returns lines up with the undisturbed timer phase.
- R6: A request raised during sleep is held. Further requests during sleep merge into that single one. The held request starts on the first machine-cycle end after sleep ends, and the refreshes that follow keep the original timer phase.
- R7: A request raised during wait states is held. It starts on the first machine-cycle end seen with wait low.
- R8: The 7-bit row address stays fixed while a strobe is high and increments by one when the strobe ends, wrapping from 127 to 0. At the n-th strobe since reset it reads (n-1) mod 128.
- R9: A write to the interval select takes effect at the next timer reload. An interval already being counted finishes at its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the interval select |
| cfg_sel | input | 2 | New interval select value |
| bus_released | input | 1 | Bus is granted to an external master |
| sleep_mode | input | 1 | Processor is in the low-power sleep state |
| wait_st | input | 1 | Current machine cycle is in a wait state |
| mcycle_end | input | 1 | Current clock closes a machine cycle |
| rfsh_active | output | 1 | Refresh strobe |
| rfsh_busy | output | 1 | Bus slot taken by refresh (start cycle or strobe) |
| rfsh_row | output | 7 | Refresh row address |

## Verification
The bound checker watches every cycle for these properties: the strobe length, the gating of every strobe start by a clean machine-cycle end, busy covering the strobe, the row address holding during a strobe and stepping by one at its end, and idle outputs under reset. Some behaviour only shows over many cycles, and the bench's scenarios cover that: the spacing produced by each interval code, the delayed effect of an interval write, the discarding of requests during bus release, the single merged replay after sleep, the hold through wait states, and the row wrap after 128 refreshes. A bench-side cycle model also runs under long stretches of random bus, sleep, wait and machine-cycle activity.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam int SEL_W   = 2;
    localparam int NUM_SEL = 1 << SEL_W;

    typedef logic [SEL_W-1:0] ivl_sel_t;

    // clock states per interval for a given select code
    function automatic int unsigned period_states(input int unsigned code,
                                                  input int unsigned base);
        return base << code;
    endfunction

endpackage

// File: rtl/ivl_timer.sv
module ivl_timer #(
    parameter int BASE_STATES = 10,
    parameter int CNT_W       = $clog2(BASE_STATES * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  drc_pkg::ivl_sel_t cfg_sel,
    output logic              tick
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        drc_pkg::ivl_sel_t sel;
    } tmr_t;

    tmr_t q, d;
    logic [CNT_W-1:0] reload_tbl [drc_pkg::NUM_SEL];

    // one reload value per select code
    for (genvar g = 0; g < drc_pkg::NUM_SEL; g++) begin : g_reload
        assign reload_tbl[g] =
            CNT_W'(drc_pkg::period_states(g, BASE_STATES) - 1);
    end

    always_comb begin
        d = q;
        if (cfg_we) begin
            d.sel = cfg_sel;
        end
        if (q.cnt == '0) begin
            d.cnt = reload_tbl[q.sel];
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= reload_tbl[0];
            q.sel <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick = (q.cnt == '0);

endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bus_released,
    input  logic sleep_mode,
    input  logic wait_st,
    input  logic mcycle_end,
    input  logic seq_idle,
    output logic start
);
    typedef struct packed {
        logic pend;
    } arb_t;

    arb_t q, d;

    always_comb begin
        start = q.pend && mcycle_end && seq_idle
                && !bus_released && !sleep_mode && !wait_st;
        d = q;
        if (bus_released) begin
            d.pend = 1'b0;          // released bus: request is dropped
        end else if (tick) begin
            d.pend = 1'b1;          // newest request replaces any held one
        end else if (start) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq #(
    parameter int RFSH_CYCLES = 3,
    parameter int ROW_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic             idle,
    output logic [ROW_W-1:0] row
);
    localparam int DUR_W = $clog2(RFSH_CYCLES + 1);

    typedef struct packed {
        logic             act;
        logic [DUR_W-1:0] dcnt;
        logic [ROW_W-1:0] row;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.act  = 1'b1;
            d.dcnt = DUR_W'(RFSH_CYCLES - 1);
        end else if (q.act) begin
            if (q.dcnt == '0) begin
                d.act = 1'b0;
                d.row = q.row + 1'b1;
            end else begin
                d.dcnt = q.dcnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.act;
    assign idle   = !q.act;
    assign row    = q.row;

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int BASE_STATES = 10,
    parameter int RFSH_CYCLES = 3,
    parameter int ROW_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic             bus_released,
    input  logic             sleep_mode,
    input  logic             wait_st,
    input  logic             mcycle_end,
    output logic             rfsh_active,
    output logic             rfsh_busy,
    output logic [ROW_W-1:0] rfsh_row
);
    localparam int CNT_W = $clog2(BASE_STATES * 8);

    logic tick;
    logic start;
    logic seq_idle;

    ivl_timer #(
        .BASE_STATES (BASE_STATES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .tick    (tick)
    );

    rfsh_arbiter u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .bus_released (bus_released),
        .sleep_mode   (sleep_mode),
        .wait_st      (wait_st),
        .mcycle_end   (mcycle_end),
        .seq_idle     (seq_idle),
        .start        (start)
    );

    rfsh_seq #(
        .RFSH_CYCLES (RFSH_CYCLES),
        .ROW_W       (ROW_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (rfsh_active),
        .idle   (seq_idle),
        .row    (rfsh_row)
    );

    assign rfsh_busy = rfsh_active | start;

endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk #(
    parameter int RFSH_CYCLES = 3,
    parameter int ROW_W       = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_released,
    input logic             sleep_mode,
    input logic             wait_st,
    input logic             mcycle_end,
    input logic             rfsh_active,
    input logic             rfsh_busy,
    input logic [ROW_W-1:0] rfsh_row
);
    localparam int LEN_W = $clog2(RFSH_CYCLES + 2);

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (rfsh_active) begin
            len_q <= len_q + 1'b1;
        end else begin
            len_q <= '0;
        end
    end

    // R2
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!rfsh_active && rfsh_row == '0));

    // R3
    strobe_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_active |-> (int'(len_q) < RFSH_CYCLES));

    // R3
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_active) |-> (int'(len_q) == RFSH_CYCLES));

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_active) |->
            $past(mcycle_end && !sleep_mode && !bus_released && !wait_st));

    // R4
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_active |-> rfsh_busy);

    // R8
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_active) |-> (rfsh_row == ROW_W'($past(rfsh_row) + 1'b1)));

    // R8
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_active |-> $stable(rfsh_row));

endmodule

bind dram_refresh_ctrl rfsh_chk #(
    .RFSH_CYCLES (RFSH_CYCLES),
    .ROW_W       (ROW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_released (bus_released),
    .sleep_mode   (sleep_mode),
    .wait_st      (wait_st),
    .mcycle_end   (mcycle_end),
    .rfsh_active  (rfsh_active),
    .rfsh_busy    (rfsh_busy),
    .rfsh_row     (rfsh_row)
);

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic       bus_released = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       wait_st = 1'b0;
    logic       mcycle_end = 1'b0;
    logic       rfsh_active;
    logic       rfsh_busy;
    logic [6:0] rfsh_row;

    always #10 clk = ~clk;   // 50 MHz

    dram_refresh_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .bus_released (bus_released),
        .sleep_mode   (sleep_mode),
        .wait_st      (wait_st),
        .mcycle_end   (mcycle_end),
        .rfsh_active  (rfsh_active),
        .rfsh_busy    (rfsh_busy),
        .rfsh_row     (rfsh_row)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int last_rise = 0;
    int gap = 0;
    int nstrobe = 0;
    int slen = 0;
    bit prev_act = 1'b0;
    bit rose = 1'b0;
    bit wrap_seen = 1'b0;
    bit nxt_we = 1'b0;
    logic [1:0] nxt_sel = 2'd0;

    // ---------------- requirement model ----------------
    int m_cnt;
    int m_sel;
    bit m_pend;
    bit m_act;
    int m_dcnt;
    int m_row;

    function automatic int period_of(input int s);
        return 10 << s;
    endfunction

    function automatic bit model_start();
        return m_pend && mcycle_end && !bus_released && !sleep_mode
               && !wait_st && !m_act;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 9; m_sel = 0; m_pend = 1'b0;
            m_act = 1'b0; m_dcnt = 0; m_row = 0;
        end else begin
            bit st;
            bit tk;
            st = model_start();
            tk = (m_cnt == 0);
            m_cnt = tk ? period_of(m_sel) - 1 : m_cnt - 1;
            if (cfg_we) m_sel = int'(cfg_sel);
            if (bus_released) m_pend = 1'b0;
            else if (tk) m_pend = 1'b1;
            else if (st) m_pend = 1'b0;
            if (st) begin
                m_act = 1'b1; m_dcnt = 2;
            end else if (m_act) begin
                if (m_dcnt == 0) begin
                    m_act = 1'b0; m_row = (m_row + 1) % 128;
                end else begin
                    m_dcnt = m_dcnt - 1;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic fail(input string req, input int act, input int exp);
        nfail++;
        $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) fail(req, act, exp);
    endtask

    task automatic step(input bit br, input bit sl, input bit wt, input bit mce);
        bit exp_busy;
        @(negedge clk);
        bus_released = br; sleep_mode = sl; wait_st = wt; mcycle_end = mce;
        cfg_we = nxt_we; cfg_sel = nxt_sel; nxt_we = 1'b0;
        #1;
        cyc++;
        exp_busy = m_act || model_start();
        nchk++;
        if (rfsh_active !== m_act) fail("R4 strobe vs model", int'(rfsh_active), int'(m_act));
        if (int'(rfsh_row) != m_row) fail("R8 row vs model", int'(rfsh_row), m_row);
        if (rfsh_busy !== exp_busy) fail("R4 busy vs model", int'(rfsh_busy), int'(exp_busy));
        rose = 1'b0;
        if (rfsh_active && !prev_act) begin
            check("R8 row at strobe", int'(rfsh_row), nstrobe % 128);
            if (nstrobe == 128 && rfsh_row == 7'd0) wrap_seen = 1'b1;
            nstrobe++;
            gap = cyc - last_rise;
            last_rise = cyc;
            rose = 1'b1;
            slen = 1;
        end else if (rfsh_active) begin
            slen++;
        end else if (prev_act) begin
            check("R3 strobe length", slen, 3);
        end
        prev_act = rfsh_active;
    endtask

    task automatic wait_rise(input bit br, input bit sl, input bit wt, input bit mce);
        int n = 0;
        do begin
            step(br, sl, wt, mce);
            n++;
        end while (!rose && n < 300);
        if (!rose) fail("R1 no strobe within limit", 0, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #3000000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int r0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R2 reset state
        check("R2 strobe in reset", int'(rfsh_active), 0);
        check("R2 busy in reset", int'(rfsh_busy), 0);
        check("R2 row in reset", int'(rfsh_row), 0);
        @(negedge clk);
        rst_n = 1'b1; mcycle_end = 1'b1;
        cyc = 0;

        // R2 first strobe after reset
        wait_rise(0, 0, 0, 1);
        check("R2 first strobe cycle", cyc, 11);
        // R1 code 00
        wait_rise(0, 0, 0, 1);
        check("R1 interval 00", gap, 10);

        // R1 / R9 other codes
        for (int s = 1; s < 4; s++) begin
            nxt_we = 1'b1; nxt_sel = 2'(s);
            wait_rise(0, 0, 0, 1);
            wait_rise(0, 0, 0, 1);
            wait_rise(0, 0, 0, 1);
            check("R1 interval code", gap, 10 << s);
        end

        // R9 write mid interval does not cut it short
        repeat (5) step(0, 0, 0, 1);
        nxt_we = 1'b1; nxt_sel = 2'd0;
        step(0, 0, 0, 1);
        wait_rise(0, 0, 0, 1);
        check("R9 old interval completes", gap, 80);
        wait_rise(0, 0, 0, 1);
        check("R9 new interval applied", gap, 10);

        // R5 bus release drops requests, phase kept
        wait_rise(0, 0, 0, 1);
        r0 = cyc;
        for (int i = 0; i < 27; i++) begin
            step(1, 0, 0, 1);
            if (rose) fail("R5 strobe during release", 1, 0);
        end
        wait_rise(0, 0, 0, 1);
        check("R5 first strobe after release", cyc - r0, 30);

        // R6 sleep latch and replay
        wait_rise(0, 0, 0, 1);
        r0 = cyc;
        for (int i = 0; i < 33; i++) begin
            step(0, 1, 0, 0);
            if (rose) fail("R6 strobe during sleep", 1, 0);
        end
        wait_rise(0, 0, 0, 1);
        check("R6 replay after sleep exit", cyc - r0, 35);
        wait_rise(0, 0, 0, 1);
        check("R6 phase after replay", cyc - r0, 40);

        // R7 wait states hold the request
        wait_rise(0, 0, 0, 1);
        r0 = cyc;
        for (int i = 0; i < 25; i++) begin
            step(0, 0, 1, 1);
            if (rose) fail("R7 strobe during wait", 1, 0);
        end
        wait_rise(0, 0, 0, 1);
        check("R7 held request issued", cyc - r0, 27);

        // R8 row wrap
        while (nstrobe < 132) wait_rise(0, 0, 0, 1);
        check("R8 row wrapped to 0", int'(wrap_seen), 1);

        // random phase against the model (R4 R5 R6 R7 R9)
        begin
            bit br = 1'b0;
            bit sl = 1'b0;
            for (int i = 0; i < 20000; i++) begin
                if (i % 40 == 0) begin
                    int mode = int'($urandom % 6);
                    br = (mode == 1);
                    sl = (mode == 2);
                end
                if ($urandom % 300 == 0) begin
                    nxt_we = 1'b1; nxt_sel = 2'($urandom % 4);
                end
                step(br, sl, ($urandom % 5) == 0, ($urandom % 3) != 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule